// File: doc/BRIEF.md
# Three-Channel Request Input Qualifier

This block watches three active-low request pins and turns a qualified request on each into a sticky flag. Each channel has a 2-bit mode field, and all three fields share one 6-bit mode input. A channel in edge mode accepts a request on a high-to-low transition of its pin. In any other mode the channel accepts a request only after an unbroken run of sixteen low samples. Those samples are taken at one of three slower rates, which come from a single free-running prescaler shared by all channels.

Each raw pin passes through a two-flop synchroniser before it is used. Once a channel's flag is set, it stays set until that channel's clear bit is pulsed. The reset input is asynchronous and active-low, and the block releases it internally on the clock edge.

Top module: `reqq_top`

## Requirements
- R1: Mode bits [1:0] control channel 0, bits [3:2] control channel 1 and bits [5:4] control channel 2. In each field, code 00 selects edge mode, 01 selects sampling every 8 clocks, 10 every 16 clocks and 11 every 128 clocks.
- R2: In edge mode, a high-to-low change on a pin sets that channel's flag on the third rising clock edge after the change. A rising change, or a pin that stays low, sets nothing.
- R3: In a sampling mode with period D, a pin that goes low and stays low does not set the flag within 15*D clocks. It does set the flag within 16*D+4 clocks.
- R4: In a sampling mode, one high sample restarts the run of sixteen. A low period cut by a high of at least 2*D clocks needs a full new run after the pin goes low again.
- R5: After a request is accepted in a sampling mode, a pin that stays low raises no further request. A new request needs at least one high sample first.
- R6: A flag stays set until its own bit of the clear input is pulsed. The clear bit affects only that channel's flag.
- R7: When a request is accepted in the same cycle that the clear bit for that channel is high, the flag ends up set.
- R8: Changing a channel's mode field restarts its sample run and reloads its edge history from the current pin level. The mode change itself never produces a request.
- R9: While reset is asserted, all flags read 0 and no pin activity sets them.
- R10: The three channels are independent. A request on one channel never changes another channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 3 | Raw active-low request pins, bit n is channel n |
| mode_i | input | 6 | Per-channel 2-bit mode fields |
| clr_i | input | 3 | Per-channel flag clear strobe |
| flag_o | output | 3 | Sticky per-channel request flags |

## Verification
A sample counter that is wrong shows up as a flag that rises too early or too late compared with the run window. Depending on the error, this appears within a single sample period up to about sixteen periods. A counter that does not saturate, or that does not restart, shows up as a flag that returns after a clear while the pin is still low. A missing restart also shows up when a high pulse or a mode change fails to delay the flag by a full run. A corrupted edge history or synchroniser moves the edge-mode flag away from its fixed three-edge latency, or makes it fire on a rising change.

// File: rtl/reqq_pkg.sv
package reqq_pkg;
  typedef enum logic [1:0] {
    QM_EDGE   = 2'b00,
    QM_SLOW_A = 2'b01,
    QM_SLOW_B = 2'b10,
    QM_SLOW_C = 2'b11
  } qmode_e;

  localparam int unsigned MODE_W = 2;
  localparam int unsigned N_RATES = 3;
endpackage

// File: rtl/reqq_sync.sv
module reqq_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  // Both stages reset to the idle (high) level of an active-low pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/reqq_prescale.sv
module reqq_prescale #(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 16,
  parameter int unsigned DIV_C = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [reqq_pkg::N_RATES-1:0] stb_o
);
  localparam int unsigned PW = $clog2(DIV_C);
  localparam int unsigned DIVS [3] = '{DIV_A, DIV_B, DIV_C};

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // A rate strobes when its low bits are all ones, so the slower strobes
  // always land on the same cycle as a faster one.
  for (genvar g = 0; g < 3; g++) begin : g_rate
    localparam logic [PW-1:0] MASK = PW'(DIVS[g] - 1);
    assign stb_o[g] = ((cnt_q & MASK) == MASK);
  end

  p_nested_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o[2] |-> (stb_o[1] && stb_o[0]));
  p_strobe_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o[0] |=> !stb_o[0]);
endmodule

// File: rtl/reqq_chan.sv
module reqq_chan
  import reqq_pkg::*;
#(
  parameter int unsigned RUN_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lvl_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [N_RATES-1:0] stb_i,
  input  logic               clr_i,
  output logic               flag_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  qmode_e        mode_q;
  logic          hist_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          mode_chg, sel_stb, edge_hit, filt_hit, acc, cnt_en;

  always_comb begin
    mode_chg = (mode_i != mode_q);
    unique case (mode_q)
      QM_SLOW_A: sel_stb = stb_i[0];
      QM_SLOW_B: sel_stb = stb_i[1];
      QM_SLOW_C: sel_stb = stb_i[2];
      default:   sel_stb = 1'b0;
    endcase
    edge_hit = (mode_q == QM_EDGE) && hist_q && !lvl_i && !mode_chg;
    filt_hit = (mode_q != QM_EDGE) && sel_stb && !lvl_i && (cnt_q == LAST) && !mode_chg;
    acc      = edge_hit || filt_hit;

    cnt_en = mode_chg || sel_stb || (mode_q == QM_EDGE);
    if (mode_chg || (mode_q == QM_EDGE) || lvl_i) cnt_d = '0;
    else if (cnt_q < FULL)                          cnt_d = cnt_q + CW'(1);
    else                                            cnt_d = cnt_q;

    if (acc)        flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= QM_EDGE;
      hist_q <= 1'b1;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= qmode_e'(mode_i);
      hist_q <= lvl_i;
      if (cnt_en) cnt_q <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  p_high_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_stb && lvl_i) |=> (cnt_q == '0));
  p_mode_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> !acc);
  p_mode_chg_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt_q == '0));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !acc) |=> !flag_o);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> flag_o);
  p_edge_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (mode_q == QM_EDGE)) |-> !lvl_i);
endmodule

// File: rtl/reqq_top.sv
module reqq_top
  import reqq_pkg::*;
#(
  parameter int unsigned NCH     = 3,
  parameter int unsigned RUN_LEN = 16,
  parameter int unsigned DIV_A   = 8,
  parameter int unsigned DIV_B   = 16,
  parameter int unsigned DIV_C   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_n_i,
  input  logic [2*NCH-1:0]  mode_i,
  input  logic [NCH-1:0]    clr_i,
  output logic [NCH-1:0]    flag_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NCH-1:0]     lvl;
  logic [N_RATES-1:0] stb;

  // Asynchronous assertion, release aligned to the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  reqq_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(req_n_i), .q_o(lvl)
  );

  reqq_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .stb_o(stb)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    reqq_chan #(.RUN_LEN(RUN_LEN)) u_ch (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .lvl_i  (lvl[c]),
      .mode_i (mode_i[MODE_W*c +: MODE_W]),
      .stb_i  (stb),
      .clr_i  (clr_i[c]),
      .flag_o (flag_o[c])
    );
  end

  p_reset_flags_r9: assert property (@(posedge clk)
    !rst_int_n |=> (flag_o == '0));
endmodule

// File: tb/reqq_top_test.sv
module reqq_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] req_n;
  logic [5:0] mode;
  logic [2:0] clr;
  logic [2:0] flags;
  int tests = 0;
  int fails = 0;

  reqq_top uut (
    .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .mode_i(mode),
    .clr_i(clr), .flag_o(flags)
  );

  always #5 clk = ~clk;

  // {pins[2:0], clr[2:0], expected flags[2:0]} for edge mode on all channels
  localparam logic [8:0] VEC [9] = '{
    {3'b111, 3'b000, 3'b000},
    {3'b110, 3'b000, 3'b001},
    {3'b100, 3'b000, 3'b011},
    {3'b100, 3'b001, 3'b010},
    {3'b111, 3'b000, 3'b010},
    {3'b011, 3'b010, 3'b100},
    {3'b000, 3'b000, 3'b111},
    {3'b000, 3'b111, 3'b000},
    {3'b111, 3'b000, 3'b000}
  };

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: flags=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input logic [2:0] m);
    clr = m; cyc(1); clr = 3'b000; cyc(1);
  endtask

  // R1 R3 R10: run one channel in a sampling mode with period d
  task automatic run_filter(input int ch, input logic [1:0] code, input int d);
    logic [2:0] one = 3'b001 << ch;
    mode[2*ch +: 2] = code; cyc(3);
    req_n[ch] = 1'b0;
    cyc(15 * d);
    chk("R3 no flag before 15*D", flags, 3'b000);
    cyc(d + 4);
    chk("R3 R1 R10 flag within 16*D+4", flags, one);
    pulse_clr(one);
    cyc(20 * d);
    chk("R5 held low raises no new request", flags, 3'b000);
    req_n[ch] = 1'b1; cyc(2 * d + 4);
    req_n[ch] = 1'b0; cyc(16 * d + 4);
    chk("R5 new request after high sample", flags, one);
    pulse_clr(one);
    req_n[ch] = 1'b1;
    mode[2*ch +: 2] = 2'b00; cyc(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_n = 3'b111; mode = 6'b0; clr = 3'b0;
    cyc(3);
    chk("R9 flags clear in reset", flags, 3'b000);
    req_n = 3'b000; cyc(4); req_n = 3'b111; cyc(4);
    chk("R9 pin activity ignored in reset", flags, 3'b000);
    rst_n = 1'b1; cyc(5);
    chk("R9 flags clear after release", flags, 3'b000);

    // R2 R6 R10 table walk
    foreach (VEC[i]) begin
      req_n = VEC[i][8:6];
      clr   = VEC[i][5:3];
      cyc(1); clr = 3'b000;
      cyc(4);
      chk($sformatf("R2 R6 R10 vector %0d", i), flags, VEC[i][2:0]);
    end

    // R2: exact latency of three rising edges
    req_n[0] = 1'b0; cyc(2);
    chk("R2 no flag after two edges", flags, 3'b000);
    cyc(1);
    chk("R2 flag on third edge", flags, 3'b001);
    pulse_clr(3'b001); req_n[0] = 1'b1; cyc(4);

    // R7: clear coinciding with acceptance
    req_n[1] = 1'b0; cyc(2);
    clr = 3'b010; cyc(1); clr = 3'b000;
    chk("R7 set wins over clear", flags, 3'b010);
    pulse_clr(3'b010); req_n[1] = 1'b1; cyc(4);

    run_filter(1, 2'b01, 8);
    run_filter(0, 2'b10, 16);
    run_filter(2, 2'b11, 128);

    // R4: a high gap restarts the run (channel 1, period 8)
    mode[3:2] = 2'b01; cyc(3);
    req_n[1] = 1'b0; cyc(100);
    req_n[1] = 1'b1; cyc(20);
    req_n[1] = 1'b0; cyc(120);
    chk("R4 run restarted by high sample", flags, 3'b000);
    cyc(12);
    chk("R4 full new run accepted", flags, 3'b010);
    pulse_clr(3'b010); req_n[1] = 1'b1; cyc(20);

    // R8: mode change restarts the run
    req_n[1] = 1'b0; cyc(100);
    mode[3:2] = 2'b10;
    cyc(240);
    chk("R8 mode change restarts run", flags, 3'b000);
    cyc(20);
    chk("R8 run completes at new rate", flags, 3'b010);
    pulse_clr(3'b010);
    mode[3:2] = 2'b00; cyc(6);
    chk("R8 change to edge mode with pin low raises nothing", flags, 3'b000);
    req_n[1] = 1'b1; cyc(4);
    chk("R2 rising change raises nothing", flags, 3'b000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule